// File: doc/BRIEF.md
# Word/Byte Parallel Control Register Write Port

This block sits on the peripheral side of an asynchronous parallel host bus. It fills a 12-bit control register from host writes. Chip-select and write-strobe are active low, and a write counts only while both are low. The two may be driven as one tied signal. All bus lines pass through a two-flop synchronizer into the system clock domain. The block commits a write when it sees the combined strobe end. The data used is the synchronized copy taken in the cycle before that end.

A static mode input chooses how writes are decoded. In word mode, one write carries all twelve bits, and data line 8 is an ordinary data bit. In byte mode, only data lines 7:0 carry data, and line 8 selects which byte is written. A low-byte write is held in a staging register. The following high-byte write supplies bits 11:8 on lines 3:0 and commits the whole word at once. Lines 7:4 of a high-byte write are reserved and must be zero. Two sticky flags, cleared only by reset, record protocol errors: one for a reserved-bit violation and one for a high byte that has no low byte before it.

The register output and its one-cycle `reg_written_o` pulse form the outgoing data path, with the pulse acting as the valid strobe. There is no ready signal. The host bus cannot be stalled, so the consumer must accept every update on the cycle it is flagged.

Top module: `pbwr_reg_port`

## Requirements
- R1: While `rst_n` is low and after it rises, `ctrl_reg_o` is 0 and `reg_written_o`, `reserved_err_o` and `seq_err_o` are all 0.
- R2: A bus cycle has effect only while `bus_cs_n_i` and `bus_wr_n_i` are both low. Strobing `bus_wr_n_i` with `bus_cs_n_i` high changes no output. Driving both pins as one tied signal performs a normal write.
- R3: A write commits at the end of the combined strobe, using the data present while the strobe was active. The result appears within four clock cycles of the strobe's deasserting edge.
- R4: Word mode (`word_mode_i` = 1): each write loads `bus_data_i[11:0]` into `ctrl_reg_o`, with line 8 treated as data bit 8.
- R5: Byte mode (`word_mode_i` = 0) with line 8 low: the write stages `bus_data_i[7:0]` as word bits 7:0 and leaves `ctrl_reg_o` unchanged. A later low-byte write replaces the staged byte.
- R6: Byte mode with line 8 high and a staged low byte: `ctrl_reg_o` becomes {`bus_data_i[3:0]`, staged byte} in a single update, and the staged byte is consumed.
- R7: `reg_written_o` is a one-cycle pulse that is high exactly on the cycles in which `ctrl_reg_o` takes a new value from a write.
- R8: A byte-mode high write with any of `bus_data_i[7:4]` nonzero sets sticky `reserved_err_o`, does not update the register, and discards the staged byte. This check takes priority over R9.
- R9: A byte-mode high write with no staged byte sets sticky `seq_err_o` and does not update the register.
- R10: A change of the synchronized mode discards any staged byte. A write that ends in the same cycle as the mode change is decoded in the new mode, with nothing staged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_mode_i | input | 1 | 1 = word mode, 0 = byte mode (static, synchronized) |
| bus_cs_n_i | input | 1 | Active-low chip-select from host |
| bus_wr_n_i | input | 1 | Active-low write strobe from host |
| bus_data_i | input | 12 | Host data; line 8 is byte select in byte mode |
| ctrl_reg_o | output | 12 | Control register contents |
| reg_written_o | output | 1 | One-cycle pulse on each register update |
| reserved_err_o | output | 1 | Sticky flag: reserved high-byte bits were nonzero |
| seq_err_o | output | 1 | Sticky flag: high byte arrived with nothing staged |

## Verification
A mode change and the end of a write strobe can reach the clock domain in the same cycle. Both travel through the same synchronizer, so the bench provokes the collision by toggling `word_mode_i` at the same instant it releases `bus_wr_n_i` on a byte-mode high write that follows a staged low byte. The expected result is that the write is decoded in word mode: the register takes all twelve lines, including line 8, a pulse is produced, and `seq_err_o` stays clear. A second collision that is checked is a reserved-bit violation together with a staged byte. Here the staged byte must be dropped, and a later lone high byte must raise `seq_err_o`.

// File: rtl/pbwr_pkg.sv
package pbwr_pkg;
  typedef enum logic [1:0] {
    WK_NONE,
    WK_WORD,
    WK_LOW,
    WK_HIGH
  } wr_kind_e;
endpackage

// File: rtl/pbwr_sync.sv
module pbwr_sync #(
  parameter int W = 8,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pbwr_strobe.sv
module pbwr_strobe #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n_s,
  input  logic          wr_n_s,
  input  logic [DW-1:0] data_s,
  output logic          strobe_end_o,
  output logic [DW-1:0] data_held_o
);
  logic active;
  logic act_q;

  assign active = ~cs_n_s & ~wr_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q       <= 1'b0;
      data_held_o <= '0;
    end else begin
      act_q <= active;
      if (active) data_held_o <= data_s;
    end
  end

  assign strobe_end_o = act_q & ~active;
endmodule

// File: rtl/pbwr_assemble.sv
module pbwr_assemble
  import pbwr_pkg::*;
#(
  parameter int WORD_W = 12,
  parameter int LOW_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_mode,
  input  logic              strobe_end,
  input  logic [WORD_W-1:0] data,
  output logic [WORD_W-1:0] ctrl_reg_o,
  output logic              reg_written_o,
  output logic              reserved_err_o,
  output logic              seq_err_o
);
  localparam int HIGH_W  = WORD_W - LOW_W;
  localparam int SEL_BIT = LOW_W;

  logic             mode_q;
  logic             mode_chg;
  logic             pend_q;
  logic             pend_eff;
  logic [LOW_W-1:0] stage_q;
  logic             rsv_bad;
  wr_kind_e         kind;

  assign mode_chg = word_mode ^ mode_q;
  assign pend_eff = pend_q & ~mode_chg;
  assign rsv_bad  = |data[LOW_W-1:HIGH_W];

  always_comb begin
    if (!strobe_end)        kind = WK_NONE;
    else if (word_mode)     kind = WK_WORD;
    else if (data[SEL_BIT]) kind = WK_HIGH;
    else                    kind = WK_LOW;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q         <= 1'b1;
      pend_q         <= 1'b0;
      stage_q        <= '0;
      ctrl_reg_o     <= '0;
      reg_written_o  <= 1'b0;
      reserved_err_o <= 1'b0;
      seq_err_o      <= 1'b0;
    end else begin
      mode_q        <= word_mode;
      pend_q        <= pend_eff;
      reg_written_o <= 1'b0;
      unique case (kind)
        WK_WORD: begin
          ctrl_reg_o    <= data;
          reg_written_o <= 1'b1;
          pend_q        <= 1'b0;
        end
        WK_LOW: begin
          stage_q <= data[LOW_W-1:0];
          pend_q  <= 1'b1;
        end
        WK_HIGH: begin
          pend_q <= 1'b0;
          if (rsv_bad) begin
            reserved_err_o <= 1'b1;
          end else if (!pend_eff) begin
            seq_err_o <= 1'b1;
          end else begin
            ctrl_reg_o    <= {data[HIGH_W-1:0], stage_q};
            reg_written_o <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pbwr_reg_port.sv
module pbwr_reg_port #(
  parameter int WORD_W      = 12,
  parameter int LOW_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_mode_i,
  input  logic              bus_cs_n_i,
  input  logic              bus_wr_n_i,
  input  logic [WORD_W-1:0] bus_data_i,
  output logic [WORD_W-1:0] ctrl_reg_o,
  output logic              reg_written_o,
  output logic              reserved_err_o,
  output logic              seq_err_o
);
  localparam int SYNC_W = WORD_W + 3;
  localparam logic [SYNC_W-1:0] SYNC_RST = {3'b111, {WORD_W{1'b0}}};

  logic [SYNC_W-1:0] sync_q;
  logic              mode_s;
  logic              cs_n_s;
  logic              wr_n_s;
  logic [WORD_W-1:0] data_s;
  logic              strobe_end;
  logic [WORD_W-1:0] data_held;

  pbwr_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({word_mode_i, bus_cs_n_i, bus_wr_n_i, bus_data_i}),
    .q    (sync_q)
  );

  assign {mode_s, cs_n_s, wr_n_s, data_s} = sync_q;

  pbwr_strobe #(.DW(WORD_W)) u_strobe (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n_s      (cs_n_s),
    .wr_n_s      (wr_n_s),
    .data_s      (data_s),
    .strobe_end_o(strobe_end),
    .data_held_o (data_held)
  );

  pbwr_assemble #(.WORD_W(WORD_W), .LOW_W(LOW_W)) u_asm (
    .clk           (clk),
    .rst_n         (rst_n),
    .word_mode     (mode_s),
    .strobe_end    (strobe_end),
    .data          (data_held),
    .ctrl_reg_o    (ctrl_reg_o),
    .reg_written_o (reg_written_o),
    .reserved_err_o(reserved_err_o),
    .seq_err_o     (seq_err_o)
  );
endmodule

// File: rtl/pbwr_port_chk.sv
module pbwr_port_chk #(
  parameter int WORD_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              strobe_end,
  input logic [WORD_W-1:0] ctrl_reg_o,
  input logic              reg_written_o,
  input logic              reserved_err_o,
  input logic              seq_err_o
);
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_written_o |=> !reg_written_o); // R7

  AST_REG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_written_o |-> ctrl_reg_o == $past(ctrl_reg_o)); // R7

  AST_UPDATE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_written_o |-> $past(strobe_end)); // R3

  AST_RSV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    reserved_err_o |=> reserved_err_o); // R8

  AST_RSV_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reserved_err_o) |-> !reg_written_o); // R8

  AST_SEQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err_o |=> seq_err_o); // R9

  AST_SEQ_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_err_o) |-> !reg_written_o); // R9
endmodule

bind pbwr_reg_port pbwr_port_chk #(.WORD_W(WORD_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .strobe_end    (strobe_end),
  .ctrl_reg_o    (ctrl_reg_o),
  .reg_written_o (reg_written_o),
  .reserved_err_o(reserved_err_o),
  .seq_err_o     (seq_err_o)
);

// File: tb/tb_pbwr_reg_port.sv
module tb_pbwr_reg_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode = 1'b1;
  logic        cs_n = 1'b1;
  logic        wr_n = 1'b1;
  logic [11:0] data = '0;
  logic [11:0] ctrl_reg;
  logic        written, rsv_err, seq_err;

  int checks = 0;
  int failures = 0;
  logic [11:0] exp_q[$];

  always #4 clk = ~clk;

  pbwr_reg_port dut (
    .clk(clk), .rst_n(rst_n), .word_mode_i(mode),
    .bus_cs_n_i(cs_n), .bus_wr_n_i(wr_n), .bus_data_i(data),
    .ctrl_reg_o(ctrl_reg), .reg_written_o(written),
    .reserved_err_o(rsv_err), .seq_err_o(seq_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: every update pulse pops one expected value
  always @(negedge clk) begin
    if (rst_n && written) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R7 unexpected update actual=%0h expected=none", ctrl_reg);
      end else begin
        logic [11:0] e;
        e = exp_q.pop_front();
        if (ctrl_reg !== e) begin
          failures++;
          $display("FAIL R3 update value actual=%0h expected=%0h", ctrl_reg, e);
        end
      end
    end
  end

  task automatic expect_upd(input logic [11:0] v);
    exp_q.push_back(v);
  endtask

  task automatic drained(input string tag);
    chk(tag, exp_q.size(), 0);
  endtask

  // cs_on: assert chip-select; tied: cs/wr move together; flip: toggle mode at strobe release
  task automatic bus_write(input logic [11:0] d, input bit cs_on, input bit tied, input bit flip);
    data = d;
    #16;
    if (tied) begin
      cs_n = 1'b0; wr_n = 1'b0;
      #40;
      cs_n = 1'b1; wr_n = 1'b1;
      if (flip) mode = ~mode;
    end else begin
      cs_n = cs_on ? 1'b0 : 1'b1;
      #8 wr_n = 1'b0;
      #40 wr_n = 1'b1;
      if (flip) mode = ~mode;
      #8 cs_n = 1'b1;
    end
    #64;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #24;
    rst_n = 1'b1;
    #24;
  endtask

  initial begin : watchdog
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    #16;
    // R1 during reset
    chk("R1 reg in reset", ctrl_reg, 0);
    chk("R1 flags in reset", {written, rsv_err, seq_err}, 0);
    rst_n = 1'b1;
    #32;
    chk("R1 reg after reset", ctrl_reg, 0);
    chk("R1 flags after reset", {written, rsv_err, seq_err}, 0);

    // R4 word mode, line 8 is data
    mode = 1'b1; #32;
    expect_upd(12'hABC); bus_write(12'hABC, 1, 0, 0);
    drained("R4 word write");
    expect_upd(12'h100); bus_write(12'h100, 1, 0, 0);
    drained("R4 bit8 as data");
    chk("R4 reg value", ctrl_reg, 12'h100);

    // R2 chip-select high: ignored
    bus_write(12'h555, 0, 0, 0);
    chk("R2 cs high ignored", ctrl_reg, 12'h100);
    drained("R2 no pulse");
    // R2 tied strobes
    expect_upd(12'h3C5); bus_write(12'h3C5, 1, 1, 0);
    drained("R2 tied write");

    // R5 / R6 byte mode
    mode = 1'b0; #32;
    bus_write(12'h05A, 1, 0, 0);
    chk("R5 low byte no update", ctrl_reg, 12'h3C5);
    expect_upd(12'h35A); bus_write(12'h103, 1, 0, 0);
    drained("R6 byte pair");
    chk("R6 reg value", ctrl_reg, 12'h35A);
    bus_write(12'h011, 1, 0, 0);
    bus_write(12'h022, 1, 0, 0);
    expect_upd(12'h722); bus_write(12'h107, 1, 0, 0);
    drained("R5 low overwrite");

    // R8 reserved bits, then R9 lone high since staging was dropped
    bus_write(12'h033, 1, 0, 0);
    bus_write(12'h113, 1, 0, 0);
    chk("R8 reserved flag", rsv_err, 1);
    chk("R8 reg unchanged", ctrl_reg, 12'h722);
    chk("R8 seq flag clear", seq_err, 0);
    bus_write(12'h102, 1, 0, 0);
    chk("R9 seq flag", seq_err, 1);
    chk("R9 reg unchanged", ctrl_reg, 12'h722);
    chk("R8 reserved sticky", rsv_err, 1);
    drained("R9 no pulse");

    do_reset();
    chk("R1 reset clears flags", {rsv_err, seq_err}, 0);
    chk("R1 reset clears reg", ctrl_reg, 0);

    // R10 mode change discards staged byte
    mode = 1'b0; #32;
    bus_write(12'h044, 1, 0, 0);
    mode = 1'b1; #48;
    mode = 1'b0; #48;
    bus_write(12'h101, 1, 0, 0);
    chk("R10 staged dropped seq flag", seq_err, 1);
    chk("R10 reg unchanged", ctrl_reg, 0);
    drained("R10 no pulse");

    // R10 mode change in the same cycle as strobe end
    do_reset();
    mode = 1'b0; #32;
    bus_write(12'h066, 1, 0, 0);
    expect_upd(12'h105); bus_write(12'h105, 1, 0, 1);
    drained("R10 coincident decoded as word");
    chk("R10 coincident reg", ctrl_reg, 12'h105);
    chk("R10 coincident no seq err", seq_err, 0);

    #40;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule